// File: doc/BRIEF.md
# Dual-Width Page-Mode ROM Read Port

This block is a clocked model of the read side of a one-time-programmable memory. The array can be read either as 16-bit words or as 8-bit bytes. The caller pulses `rdReq` with a word address while the chip is selected. A fixed number of cycles later the block raises `rdy` for one cycle, and from that cycle on the fetched value appears on the data outputs. When the chip is deselected or its outputs are disabled, the data lines stay in high impedance. Each data bit has its own enable in `dataOe`, so bits whose enable is low are treated as undriven.

In byte mode the top data pin is no longer an output. It becomes an input, `lsbIn`, that supplies the lowest byte-address bit and picks one half of the word. Consecutive reads that stay inside one eight-word page complete faster than a random read. The page is closed when chip select, width mode or identification mode changes. An identification flag replaces the array with two fixed codes, a manufacturer code and a device code, and bit 15 of each code gives the code odd parity. The array is a small register file that is loaded with a fixed pattern at reset.

Top module: `pageRomRead`

## Requirements
- R1: After reset `rdy` is low, no page is open, and no read is in progress.
- R2: While `ceN` is high, `dataOe` is all zeros and `rdReq` does not start a read (no `rdy` follows).
- R3: While `ceN` is low and `oeN` is high, `dataOe` and `dataOut` are all zeros, but a requested read still completes. Its data appears once `oeN` goes low.
- R4: In word mode (`wordMode`=1), with `ceN` and `oeN` both low, `dataOe` is 16'hFFFF and `dataOut` is the 16-bit value of the last completed read.
- R5: In byte mode (`wordMode`=0), `dataOe` is 16'h00FF when driving. `dataOut[7:0]` holds bits 7:0 of the word when `lsbIn` was 0 at the request, and bits 15:8 when `lsbIn` was 1. `dataOut[15:8]` is zero.
- R6: A read accepted on clock edge k that misses the page raises `rdy` for exactly one cycle after edge k+4.
- R7: A read whose address bits [5:3] equal those of the previous array read, with the page still open, raises `rdy` after edge k+2.
- R8: A change of `ceN`, a change of `wordMode`, or an identification read closes the page, so the next array read takes the random-access latency.
- R9: Word i (6-bit word address) holds {~i[7:0], i[7:0]} for i < 32. Words 32 to 63 are erased and read as 16'hFFFF.
- R10: With `idMode`=1, a read returns the manufacturer code when `addr[0]`=0 and the device code when `addr[0]`=1. Bits 14:0 are the configured payload and bit 15 makes the number of ones odd.
- R11: A `rdReq` that arrives while a read is in progress is ignored. No second `rdy` follows and the data is not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| wordMode | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| idMode | input | 1 | Selects identification codes instead of the array |
| rdReq | input | 1 | Read request pulse |
| addr | input | 6 | Word address |
| lsbIn | input | 1 | Byte-select bit; used only in byte mode, taking the place of the top data pin |
| rdy | output | 1 | One-cycle pulse, read data valid |
| dataOut | output | 16 | Read data; zero where not driven |
| dataOe | output | 16 | Per-bit drive enable (0 = high impedance) |

## Verification
Some rules are checked on every cycle by the assertions. No enable is raised in standby. The upper byte enables stay low in byte mode. `rdy` lasts a single cycle. Every `rdy` arrives after exactly the latency that matches the page hit or miss of its request. No read starts while the chip is deselected. An identification word always has odd parity. Other behaviour only the directed scenarios can show. These are the stored pattern and the erased region, the choice of byte half by `lsbIn`, and which mode changes actually close the page. The same holds for a request during a busy read being dropped, and for held data appearing once `oeN` falls.

// File: rtl/pageRomPkg.sv
package pageRomPkg;
  typedef struct packed {
    logic capture;  // load the output register this cycle
    logic useId;    // source is an identification code
    logic idSel;    // 0 = manufacturer, 1 = device
    logic byteHi;   // byte mode: upper half selected
  } romStrobe_t;
endpackage

// File: rtl/pageRomCtrl.sv
module pageRomCtrl
  import pageRomPkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PAGE_W   = 3,
  parameter int RAND_LAT = 4,
  parameter int HIT_LAT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              wordMode,
  input  logic              idMode,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lsbIn,
  output romStrobe_t        strobe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdy
);
  localparam int CNT_W = $clog2(RAND_LAT) > 0 ? $clog2(RAND_LAT) : 1;
  localparam int EL_W  = $clog2(RAND_LAT + 1);
  localparam int TAG_W = ADDR_W - PAGE_W;

  logic             busy, pageOpen, lastHit;
  logic             cePrev, wmPrev, idPrev;
  logic [CNT_W-1:0] cnt;
  logic [EL_W-1:0]  elapsed;
  logic [TAG_W-1:0] pageTag;
  logic             useIdReg, idSelReg, byteHiReg;
  logic             accept, modeChg, hit, finish;

  assign accept  = rdReq && !ceN && !busy;
  assign modeChg = (ceN != cePrev) || (wordMode != wmPrev) || (idMode != idPrev);
  assign hit     = pageOpen && !modeChg && !idMode &&
                   (addr[ADDR_W-1:PAGE_W] == pageTag);
  assign finish  = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      pageOpen  <= 1'b0;
      lastHit   <= 1'b0;
      cePrev    <= 1'b1;
      wmPrev    <= 1'b1;
      idPrev    <= 1'b0;
      cnt       <= '0;
      elapsed   <= '0;
      pageTag   <= '0;
      rdAddr    <= '0;
      useIdReg  <= 1'b0;
      idSelReg  <= 1'b0;
      byteHiReg <= 1'b0;
      rdy       <= 1'b0;
    end else begin
      cePrev <= ceN;
      wmPrev <= wordMode;
      idPrev <= idMode;
      rdy    <= 1'b0;
      if (modeChg) pageOpen <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        cnt       <= hit ? CNT_W'(HIT_LAT - 1) : CNT_W'(RAND_LAT - 1);
        elapsed   <= '0;
        lastHit   <= hit;
        rdAddr    <= addr;
        useIdReg  <= idMode;
        idSelReg  <= addr[0];
        byteHiReg <= !wordMode && lsbIn;
        pageTag   <= addr[ADDR_W-1:PAGE_W];
        pageOpen  <= !idMode;
      end else if (busy) begin
        elapsed <= elapsed + 1'b1;
        if (finish) begin
          busy <= 1'b0;
          rdy  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.capture = finish;
    strobe.useId   = useIdReg;
    strobe.idSel   = idSelReg;
    strobe.byteHi  = byteHiReg;
  end

  // R6 / R7: ready arrives exactly after the latency chosen at acceptance
  p_latency_r6_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdy |-> (elapsed == (lastHit ? EL_W'(HIT_LAT) : EL_W'(RAND_LAT))));

  // R6: ready is a single-cycle pulse
  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdy |=> !rdy);

  // R2: no read begins while deselected
  p_no_start_standby_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(ceN));
endmodule

// File: rtl/pageRomData.sv
module pageRomData
  import pageRomPkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter logic [14:0] MFR_CODE = 15'h00C2,
  parameter logic [14:0] DEV_CODE = 15'h1051
) (
  input  logic              clk,
  input  logic              rstN,
  input  romStrobe_t        strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              wordMode,
  output logic [15:0]       dataOut,
  output logic [15:0]       dataOe
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PROG_WORDS = DEPTH / 2;
  localparam logic [15:0] MFR_WORD = {~^MFR_CODE, MFR_CODE};
  localparam logic [15:0] DEV_WORD = {~^DEV_CODE, DEV_CODE};

  logic [15:0] mem [DEPTH];
  logic [15:0] dataReg;
  logic        hiReg;
  logic        driveEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= (i < PROG_WORDS) ? {~8'(i), 8'(i)} : 16'hFFFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= 16'hFFFF;
      hiReg   <= 1'b0;
    end else if (strobe.capture) begin
      dataReg <= strobe.useId ? (strobe.idSel ? DEV_WORD : MFR_WORD) : mem[rdAddr];
      hiReg   <= strobe.byteHi;
    end
  end

  assign driveEn = !ceN && !oeN;

  always_comb begin
    dataOe  = '0;
    dataOut = '0;
    if (driveEn) begin
      if (wordMode) begin
        dataOe  = 16'hFFFF;
        dataOut = dataReg;
      end else begin
        dataOe  = 16'h00FF;
        dataOut = {8'h00, hiReg ? dataReg[15:8] : dataReg[7:0]};
      end
    end
  end

  // R2: deselected chip drives nothing
  p_standby_hiz_r2: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (dataOe == 16'h0000));

  // R5: upper byte lanes are never driven in byte mode
  p_byte_upper_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wordMode |-> (dataOe[15:8] == 8'h00));

  // R10: identification words carry odd parity
  p_id_parity_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.useId) |=> (^dataReg == 1'b1));
endmodule

// File: rtl/pageRomRead.sv
module pageRomRead
  import pageRomPkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          PAGE_W   = 3,
  parameter int          RAND_LAT = 4,
  parameter int          HIT_LAT  = 2,
  parameter logic [14:0] MFR_CODE = 15'h00C2,
  parameter logic [14:0] DEV_CODE = 15'h1051
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              wordMode,
  input  logic              idMode,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lsbIn,
  output logic              rdy,
  output logic [15:0]       dataOut,
  output logic [15:0]       dataOe
);
  romStrobe_t        strobe;
  logic [ADDR_W-1:0] rdAddr;

  pageRomCtrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .RAND_LAT(RAND_LAT), .HIT_LAT(HIT_LAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .wordMode(wordMode), .idMode(idMode),
    .rdReq(rdReq), .addr(addr), .lsbIn(lsbIn),
    .strobe(strobe), .rdAddr(rdAddr), .rdy(rdy)
  );

  pageRomData #(
    .ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr),
    .ceN(ceN), .oeN(oeN), .wordMode(wordMode),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/pageRomRead_test.sv
`timescale 1ns/1ps
module pageRomRead_test;
  localparam logic [14:0] MFR = 15'h00C2;
  localparam logic [14:0] DEV = 15'h1051;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, wordMode = 1'b1, idMode = 1'b0;
  logic        rdReq = 1'b0, lsbIn = 1'b0;
  logic [5:0]  addr = '0;
  logic        rdy;
  logic [15:0] dataOut, dataOe;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pageRomRead #(.MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .wordMode(wordMode),
    .idMode(idMode), .rdReq(rdReq), .addr(addr), .lsbIn(lsbIn),
    .rdy(rdy), .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic [15:0] wordAt(input int i);
    return (i < 32) ? {~8'(i), 8'(i)} : 16'hFFFF;
  endfunction

  function automatic logic [15:0] idWord(input logic [14:0] c);
    return {~^c, c};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Issue one read and measure the edges until rdy
  task automatic doRead(input logic [5:0] a, input logic lsb, input int expLat,
                        input logic [15:0] expData, input logic [15:0] expOe,
                        input string req);
    int n;
    @(negedge clk);
    addr = a; lsbIn = lsb; rdReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdReq = 1'b0;
    n = 0;
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rdy) begin n = i; break; end
    end
    check(n == expLat, {req, " latency"}, n, expLat);
    check(dataOut == expData, {req, " data"}, dataOut, expData);
    check(dataOe == expOe, {req, " enables"}, dataOe, expOe);
    @(negedge clk);
    check(!rdy, {req, " single pulse"}, rdy, 0);
  endtask

  task automatic testReset();
    check(rdy == 1'b0, "R1 rdy after reset", rdy, 0);
    check(dataOe == 16'h0, "R1 enables after reset", dataOe, 0);
  endtask

  task automatic testStandby();
    bit seen = 0;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b0; rdReq = 1'b1; addr = 6'd5;
    @(negedge clk);
    rdReq = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (rdy) seen = 1;
    end
    check(!seen, "R2 request ignored in standby", seen, 0);
    check(dataOe == 16'h0, "R2 standby enables", dataOe, 0);
    ceN = 1'b0;
    idle(2);
  endtask

  task automatic testWordReads();
    doRead(6'd5, 0, 4, wordAt(5), 16'hFFFF, "R6 R4 R9 random word");
    doRead(6'd6, 0, 2, wordAt(6), 16'hFFFF, "R7 page hit");
    doRead(6'd8, 0, 4, wordAt(8), 16'hFFFF, "R6 page miss");
    doRead(6'd40, 0, 4, 16'hFFFF, 16'hFFFF, "R9 erased word");
  endtask

  task automatic testOutputDisable();
    @(negedge clk);
    oeN = 1'b1;
    doRead(6'd10, 0, 4, 16'h0000, 16'h0000, "R3 outputs off");
    oeN = 1'b0;
    #0.1;
    check(dataOut == wordAt(10), "R3 data after enable", dataOut, wordAt(10));
    check(dataOe == 16'hFFFF, "R3 enables after enable", dataOe, 16'hFFFF);
  endtask

  task automatic testByteMode();
    @(negedge clk);
    wordMode = 1'b0;
    idle(1);
    doRead(6'd3, 0, 4, 16'h0003, 16'h00FF, "R5 R8 low byte after mode change");
    doRead(6'd3, 1, 2, 16'h00FC, 16'h00FF, "R5 R7 high byte page hit");
    @(negedge clk);
    wordMode = 1'b1;
    idle(1);
    doRead(6'd3, 0, 4, wordAt(3), 16'hFFFF, "R8 width change closes page");
  endtask

  task automatic testCeToggle();
    @(negedge clk);
    ceN = 1'b1;
    @(negedge clk);
    ceN = 1'b0;
    idle(1);
    doRead(6'd4, 0, 4, wordAt(4), 16'hFFFF, "R8 select change closes page");
  endtask

  task automatic testIdMode();
    @(negedge clk);
    idMode = 1'b1;
    doRead(6'd0, 0, 4, idWord(MFR), 16'hFFFF, "R10 manufacturer code");
    doRead(6'd1, 0, 4, idWord(DEV), 16'hFFFF, "R10 device code");
    check(^dataOut == 1'b1, "R10 odd parity", dataOut, idWord(DEV));
    @(negedge clk);
    idMode = 1'b0;
    idle(1);
    doRead(6'd1, 0, 4, wordAt(1), 16'hFFFF, "R8 id mode closes page");
  endtask

  task automatic testBusyIgnore();
    bit seen = 0;
    @(negedge clk);
    addr = 6'd5; rdReq = 1'b1;
    @(negedge clk);
    addr = 6'd20;
    @(negedge clk);
    rdReq = 1'b0;
    @(negedge clk);
    check(rdy == 1'b1, "R11 first read ready on hit", rdy, 1);
    check(dataOut == wordAt(5), "R11 first read data", dataOut, wordAt(5));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (rdy) seen = 1;
    end
    check(!seen, "R11 no second ready", seen, 0);
    check(dataOut == wordAt(5), "R11 data kept", dataOut, wordAt(5));
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);
    testReset();
    testStandby();
    testWordReads();
    testOutputDisable();
    testByteMode();
    testCeToggle();
    testIdMode();
    testBusyIgnore();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule